// File: doc/BRIEF.md
# Shared Interrupt Source Router

This block collects a configurable number of external interrupt lines and steers each one to a single interrupt pin of a single processor core. Every source keeps four pieces of state: a pending flag, an enable flag, a destination pin number and a destination core. Each core/pin output is the OR of the sources that are enabled, pending and aimed at that pair. Each core also has a local timer-compare interrupt that joins the OR on a pin chosen by software.

Software reaches the state through a small word-addressed register bus. `bus_addr[11:8]` selects a region and `bus_addr[7:0]` an index. The regions are:

- 0: pending bitmap (read)
- 1: enable bitmap (read)
- 2: enable-set port (write)
- 3: enable-clear port (write)
- 4: pin map, one word per source
- 5: core map, one word per source
- 6: wedge port (write, index 0)
- 7: local-compare route, one word per core

Bitmap word `k`, bit `b` stands for source `32*k+b`. A read returns its data in `bus_rdata` one cycle after `bus_rd`, and `bus_rdata` is zero in every other cycle. `cpu_irq` bit `core*NUM_PIN+pin` is the line for that core and pin.

Top module: `irq_source_router`

## Requirements
- R1: After reset every source is disabled and not pending. Its pin map reads 0x8000_0000 and its core map reads 0. Every local route reads 0x8000_0000 (routed, pin 0). `cpu_irq`, `bus_err` and `bus_rdata` are 0.
- R2: A write to region 2, word k sets the enable of source 32k+b for each data bit b that is 1. Bits that are 0 leave the enable as it was.
- R3: A write to region 3, word k clears the enable of source 32k+b for each data bit b that is 1. Bits that are 0 leave the enable as it was.
- R4: A read of region 0 or 1, word k, returns the pending or enable flags of sources 32k..32k+31 one cycle later. Bits for sources at or above NUM_SRC read 0. Words at or above ceil(NUM_SRC/32) are out of range.
- R5: A core map write stores the index of the lowest set data bit as the target core. Zero data makes the source unmapped. A read returns 1 shifted left by the core index, or 0 when the source is unmapped.
- R6: A pin map write keeps bit 31 (the map flag) and bits 5:0 (the pin). It is rejected when bits 5:0 exceed NUM_PIN-1.
- R7: A core map write is rejected when its lowest set bit index is not below NUM_CORE.
- R8: A write of the wedge port sets the pending flag of source data[30:0] to data[31]. A source number at or above NUM_SRC is rejected.
- R9: When a source line changes level, its pending flag takes the new level on the next clock. A wedge write to the same source in the same cycle wins over the line.
- R10: `cpu_irq[c*NUM_PIN+p]` is the OR of pending&enabled sources mapped to core c and pin p. A disabled source still records its pending flag but drives nothing.
- R11: `loc_irq[c]` drives `cpu_irq[c*NUM_PIN+pin]` while the route register of core c has bit 31 set, where pin is bits 5:0. A route write is rejected when the pin exceeds NUM_PIN-1 or the index is not below NUM_CORE.
- R12: A rejected write, an out-of-range index, or an access a region does not support raises `bus_err` for exactly one cycle after the access. It leaves all state unchanged, and such a read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_irq | input | NUM_SRC | External source lines (level) |
| loc_irq | input | NUM_CORE | Per-core local compare interrupt |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Region in [11:8], index in [7:0] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after bus_rd |
| bus_err | output | 1 | One-cycle error pulse |
| cpu_irq | output | NUM_CORE*NUM_PIN | Per core/pin interrupt lines |

## Verification
Two mechanisms can update the same pending flag in one clock: a level change on the source line and a wedge write. The bench provokes this by raising a line on the same edge that a wedge write clears that source. A behavioural model, updated on every clock, expects the wedge value to survive. The pending bitmap read-back and the per-cycle comparison of `cpu_irq` judge the outcome.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 12;
    localparam int IDX_W    = 8;
    localparam int PIN_W    = 6;
    localparam int CORE_W   = 5;
    localparam int FLAG_BIT = 31;
    localparam int WORD_BITS = 32;

    typedef enum logic [3:0] {
        REG_PEND  = 4'd0,
        REG_EN    = 4'd1,
        REG_SET   = 4'd2,
        REG_CLR   = 4'd3,
        REG_PIN   = 4'd4,
        REG_CORE  = 4'd5,
        REG_WEDGE = 4'd6,
        REG_LOCAL = 4'd7
    } reg_region_e;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_SET   = 3'd1,
        OP_CLR   = 3'd2,
        OP_PIN   = 3'd3,
        OP_CORE  = 3'd4,
        OP_WEDGE = 3'd5,
        OP_LOCAL = 3'd6
    } wr_op_e;

    typedef struct packed {
        wr_op_e              op;
        logic [IDX_W-1:0]    idx;
        logic [DATA_W-1:0]   data;
        logic                core_vld;
        logic [CORE_W-1:0]   core;
    } wr_cmd_t;

    typedef struct packed {
        logic                pend;
        logic                en;
        logic                flag;
        logic [PIN_W-1:0]    pin;
        logic                core_vld;
        logic [CORE_W-1:0]   core;
    } src_state_t;

    // Index of the lowest set bit; DATA_W when the value is zero.
    function automatic logic [CORE_W:0] lowest_set(input logic [DATA_W-1:0] v);
        logic [CORE_W:0] r;
        r = (CORE_W+1)'(DATA_W);
        for (int i = DATA_W - 1; i >= 0; i--) begin
            if (v[i]) r = (CORE_W+1)'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC  = 40,
    parameter int NUM_CORE = 3,
    parameter int NUM_PIN  = 6
) (
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output wr_cmd_t              cmd,
    output logic                 acc_err
);
    localparam int NWORD = (NUM_SRC + WORD_BITS - 1) / WORD_BITS;

    logic [3:0]        region;
    logic [IDX_W-1:0]  idx;
    logic [CORE_W:0]   low;
    logic src_ok, word_ok, core_ok, pin_ok, wedge_ok, core_map_ok;
    logic wr_ok, rd_ok;
    wr_op_e op;

    assign region      = bus_addr[ADDR_W-1:IDX_W];
    assign idx         = bus_addr[IDX_W-1:0];
    assign low         = lowest_set(bus_wdata);
    assign src_ok      = int'(idx) < NUM_SRC;
    assign word_ok     = int'(idx) < NWORD;
    assign core_ok     = int'(idx) < NUM_CORE;
    assign pin_ok      = int'(bus_wdata[PIN_W-1:0]) <= NUM_PIN - 1;
    assign wedge_ok    = (idx == '0) && (int'(bus_wdata[FLAG_BIT-1:0]) < NUM_SRC);
    assign core_map_ok = (bus_wdata == '0) || (int'(low) < NUM_CORE);

    always_comb begin
        wr_ok = 1'b0;
        rd_ok = 1'b0;
        op    = OP_NONE;
        case (region)
            REG_PEND:  rd_ok = word_ok;
            REG_EN:    rd_ok = word_ok;
            REG_SET:   begin wr_ok = word_ok; op = OP_SET; end
            REG_CLR:   begin wr_ok = word_ok; op = OP_CLR; end
            REG_PIN:   begin wr_ok = src_ok && pin_ok; rd_ok = src_ok; op = OP_PIN; end
            REG_CORE:  begin wr_ok = src_ok && core_map_ok; rd_ok = src_ok; op = OP_CORE; end
            REG_WEDGE: begin wr_ok = wedge_ok; op = OP_WEDGE; end
            REG_LOCAL: begin wr_ok = core_ok && pin_ok; rd_ok = core_ok; op = OP_LOCAL; end
            default:   ;
        endcase
    end

    always_comb begin
        cmd.op       = (bus_wr && wr_ok) ? op : OP_NONE;
        cmd.idx      = (op == OP_WEDGE) ? bus_wdata[IDX_W-1:0] : idx;
        cmd.data     = bus_wdata;
        cmd.core_vld = bus_wdata != '0;
        cmd.core     = low[CORE_W-1:0];
    end

    assign acc_err = (bus_wr && !wr_ok) || (bus_rd && !rd_ok);

endmodule

// File: rtl/irq_src_slot.sv
module irq_src_slot
    import irq_route_pkg::*;
#(
    parameter int SRC_IDX = 0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       line,
    input  wr_cmd_t    cmd,
    output src_state_t st
);
    localparam int WORD = SRC_IDX / WORD_BITS;
    localparam int BIT  = SRC_IDX % WORD_BITS;

    logic line_q;
    logic hit_set, hit_clr, hit_pin, hit_core, hit_wedge;

    assign hit_set   = (cmd.op == OP_SET) && (cmd.idx == IDX_W'(WORD)) && cmd.data[BIT];
    assign hit_clr   = (cmd.op == OP_CLR) && (cmd.idx == IDX_W'(WORD)) && cmd.data[BIT];
    assign hit_pin   = (cmd.op == OP_PIN)   && (cmd.idx == IDX_W'(SRC_IDX));
    assign hit_core  = (cmd.op == OP_CORE)  && (cmd.idx == IDX_W'(SRC_IDX));
    assign hit_wedge = (cmd.op == OP_WEDGE) && (cmd.idx == IDX_W'(SRC_IDX));

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= 1'b0;
            st     <= '{pend: 1'b0, en: 1'b0, flag: 1'b1, pin: '0,
                        core_vld: 1'b0, core: '0};
        end else begin
            line_q <= line;
            if (line != line_q) st.pend <= line;
            if (hit_wedge)      st.pend <= cmd.data[FLAG_BIT];
            if (hit_set)        st.en   <= 1'b1;
            if (hit_clr)        st.en   <= 1'b0;
            if (hit_pin) begin
                st.flag <= cmd.data[FLAG_BIT];
                st.pin  <= cmd.data[PIN_W-1:0];
            end
            if (hit_core) begin
                st.core_vld <= cmd.core_vld;
                st.core     <= cmd.core;
            end
        end
    end

    p_set_enables_r2: assert property (@(posedge clk) disable iff (rst)
        hit_set |=> st.en);

    p_clr_disables_r3: assert property (@(posedge clk) disable iff (rst)
        hit_clr |=> !st.en);

    p_core_target_r5: assert property (@(posedge clk) disable iff (rst)
        (hit_core && cmd.core_vld) |=> (st.core_vld && st.core == $past(cmd.core)));

    p_wedge_wins_r9: assert property (@(posedge clk) disable iff (rst)
        hit_wedge |=> (st.pend == $past(cmd.data[FLAG_BIT])));

    p_pend_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (line == line_q && !hit_wedge) |=> $stable(st.pend));

endmodule

// File: rtl/irq_pin_router.sv
module irq_pin_router
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC  = 40,
    parameter int NUM_CORE = 3,
    parameter int NUM_PIN  = 6
) (
    input  logic                          clk,
    input  logic                          rst,
    input  src_state_t [NUM_SRC-1:0]      st,
    input  logic [NUM_CORE-1:0]           loc_irq,
    input  logic [NUM_CORE-1:0]           loc_en,
    input  logic [NUM_CORE*PIN_W-1:0]     loc_pin,
    output logic [NUM_CORE*NUM_PIN-1:0]   cpu_irq
);
    logic [NUM_SRC-1:0] live;

    always_comb begin
        for (int s = 0; s < NUM_SRC; s++) begin
            live[s] = st[s].en && st[s].pend && st[s].core_vld;
        end
    end

    for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
        for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
            logic acc;
            always_comb begin
                acc = loc_irq[c] && loc_en[c] &&
                      (loc_pin[c*PIN_W +: PIN_W] == PIN_W'(p));
                for (int s = 0; s < NUM_SRC; s++) begin
                    acc = acc || (live[s] && st[s].core == CORE_W'(c) &&
                                  st[s].pin == PIN_W'(p));
                end
            end
            assign cpu_irq[c*NUM_PIN + p] = acc;
        end
    end

    p_quiet_when_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (live == '0 && loc_irq == '0) |-> (cpu_irq == '0));

endmodule

// File: rtl/irq_source_router.sv
module irq_source_router
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC  = 40,
    parameter int NUM_CORE = 3,
    parameter int NUM_PIN  = 6
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_SRC-1:0]            src_irq,
    input  logic [NUM_CORE-1:0]           loc_irq,
    input  logic                          bus_wr,
    input  logic                          bus_rd,
    input  logic [11:0]                   bus_addr,
    input  logic [31:0]                   bus_wdata,
    output logic [31:0]                   bus_rdata,
    output logic                          bus_err,
    output logic [NUM_CORE*NUM_PIN-1:0]   cpu_irq
);
    localparam int NWORD = (NUM_SRC + WORD_BITS - 1) / WORD_BITS;
    localparam int VEC_W = NWORD * WORD_BITS;

    wr_cmd_t                     cmd;
    logic                        acc_err;
    src_state_t [NUM_SRC-1:0]    st;
    logic [NUM_CORE-1:0]         loc_en;
    logic [NUM_CORE*PIN_W-1:0]   loc_pin;
    logic [VEC_W-1:0]            pend_vec, en_vec;
    logic [DATA_W-1:0]           rd_val;
    logic [IDX_W-1:0]            idx;

    assign idx = bus_addr[IDX_W-1:0];

    irq_reg_decode #(.NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE), .NUM_PIN(NUM_PIN)) u_dec (
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .cmd(cmd), .acc_err(acc_err)
    );

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        irq_src_slot #(.SRC_IDX(s)) u_slot (
            .clk(clk), .rst(rst), .line(src_irq[s]), .cmd(cmd), .st(st[s])
        );
    end

    for (genvar c = 0; c < NUM_CORE; c++) begin : g_local
        always_ff @(posedge clk) begin
            if (rst) begin
                loc_en[c]                  <= 1'b1;
                loc_pin[c*PIN_W +: PIN_W]  <= '0;
            end else if (cmd.op == OP_LOCAL && cmd.idx == IDX_W'(c)) begin
                loc_en[c]                  <= cmd.data[FLAG_BIT];
                loc_pin[c*PIN_W +: PIN_W]  <= cmd.data[PIN_W-1:0];
            end
        end
    end

    irq_pin_router #(.NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE), .NUM_PIN(NUM_PIN)) u_route (
        .clk(clk), .rst(rst), .st(st), .loc_irq(loc_irq), .loc_en(loc_en),
        .loc_pin(loc_pin), .cpu_irq(cpu_irq)
    );

    always_comb begin
        pend_vec = '0;
        en_vec   = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            pend_vec[s] = st[s].pend;
            en_vec[s]   = st[s].en;
        end
    end

    always_comb begin
        rd_val = '0;
        case (bus_addr[11:8])
            REG_PEND: for (int w = 0; w < NWORD; w++)
                          if (idx == IDX_W'(w)) rd_val = pend_vec[w*WORD_BITS +: WORD_BITS];
            REG_EN:   for (int w = 0; w < NWORD; w++)
                          if (idx == IDX_W'(w)) rd_val = en_vec[w*WORD_BITS +: WORD_BITS];
            REG_PIN:  for (int s = 0; s < NUM_SRC; s++)
                          if (idx == IDX_W'(s)) begin
                              rd_val[FLAG_BIT]    = st[s].flag;
                              rd_val[PIN_W-1:0]   = st[s].pin;
                          end
            REG_CORE: for (int s = 0; s < NUM_SRC; s++)
                          if (idx == IDX_W'(s) && st[s].core_vld)
                              rd_val = DATA_W'(1) << st[s].core;
            REG_LOCAL: for (int c = 0; c < NUM_CORE; c++)
                          if (idx == IDX_W'(c)) begin
                              rd_val[FLAG_BIT]  = loc_en[c];
                              rd_val[PIN_W-1:0] = loc_pin[c*PIN_W +: PIN_W];
                          end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            bus_rdata <= (bus_rd && !acc_err) ? rd_val : '0;
            bus_err   <= acc_err;
        end
    end

    p_err_follows_access_r12: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> $past(bus_wr || bus_rd));

    p_rdata_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_rd) |-> (bus_rdata == '0));

    p_core_read_onehot_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(bus_rd) && $past(bus_addr[11:8]) == REG_CORE) |-> $onehot0(bus_rdata));

    p_local_drives_pin_r11: assert property (@(posedge clk) disable iff (rst)
        (loc_irq[0] && loc_en[0] && int'(loc_pin[PIN_W-1:0]) < NUM_PIN)
            |-> cpu_irq[loc_pin[PIN_W-1:0]]);

endmodule

// File: tb/irq_source_router_tb.sv
module irq_source_router_tb;
    localparam int CLK_P = 10;
    localparam int NS = 40;
    localparam int NC = 3;
    localparam int NP = 6;
    localparam int NW = (NS + 31) / 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NS-1:0] src_irq = '0;
    logic [NC-1:0] loc_irq = '0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic bus_err;
    logic [NC*NP-1:0] cpu_irq;

    int checks = 0, fails = 0;
    bit mon_on = 0, done = 0;
    string cur_req = "R1";

    // behavioural reference state
    bit m_pend[NS], m_en[NS], m_flag[NS], m_prev[NS];
    int m_pin[NS], m_core[NS];
    bit m_loc_en[NC];
    int m_loc_pin[NC];
    bit exp_err;
    logic [31:0] exp_rdata;

    always #(CLK_P/2) clk = ~clk;

    irq_source_router #(.NUM_SRC(NS), .NUM_CORE(NC), .NUM_PIN(NP)) u_dut (
        .clk(clk), .rst(rst), .src_irq(src_irq), .loc_irq(loc_irq),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .cpu_irq(cpu_irq)
    );

    function automatic logic [NC*NP-1:0] model_irq();
        logic [NC*NP-1:0] r;
        r = '0;
        for (int s = 0; s < NS; s++)
            if (m_en[s] && m_pend[s] && m_core[s] >= 0) r[m_core[s]*NP + m_pin[s]] = 1'b1;
        for (int c = 0; c < NC; c++)
            if (loc_irq[c] && m_loc_en[c]) r[c*NP + m_loc_pin[c]] = 1'b1;
        return r;
    endfunction

    always @(posedge clk) begin
        int rg, ix, low, src;
        bit e;
        logic [31:0] rv;
        if (rst) begin
            for (int s = 0; s < NS; s++) begin
                m_pend[s] = 0; m_en[s] = 0; m_flag[s] = 1; m_prev[s] = 0;
                m_pin[s] = 0; m_core[s] = -1;
            end
            for (int c = 0; c < NC; c++) begin m_loc_en[c] = 1; m_loc_pin[c] = 0; end
            exp_err = 0; exp_rdata = 0;
        end else begin
            rg = int'(bus_addr[11:8]); ix = int'(bus_addr[7:0]);
            e = 0; rv = 0;
            if (bus_rd) begin
                case (rg)
                    0, 1: if (ix < NW) begin
                              for (int b = 0; b < 32; b++)
                                  if (32*ix + b < NS)
                                      rv[b] = (rg == 0) ? m_pend[32*ix+b] : m_en[32*ix+b];
                          end else e = 1;
                    4: if (ix < NS) begin rv[31] = m_flag[ix]; rv[5:0] = 6'(m_pin[ix]); end
                       else e = 1;
                    5: if (ix < NS) begin if (m_core[ix] >= 0) rv = 32'd1 << m_core[ix]; end
                       else e = 1;
                    7: if (ix < NC) begin rv[31] = m_loc_en[ix]; rv[5:0] = 6'(m_loc_pin[ix]); end
                       else e = 1;
                    default: e = 1;
                endcase
            end
            for (int s = 0; s < NS; s++) begin
                if (src_irq[s] != m_prev[s]) m_pend[s] = src_irq[s];
                m_prev[s] = src_irq[s];
            end
            if (bus_wr) begin
                case (rg)
                    2, 3: if (ix < NW) begin
                              for (int b = 0; b < 32; b++)
                                  if (32*ix + b < NS && bus_wdata[b]) m_en[32*ix+b] = (rg == 2);
                          end else e = 1;
                    4: if (ix < NS && int'(bus_wdata[5:0]) < NP) begin
                           m_flag[ix] = bus_wdata[31]; m_pin[ix] = int'(bus_wdata[5:0]);
                       end else e = 1;
                    5: if (ix >= NS) e = 1;
                       else if (bus_wdata == 0) m_core[ix] = -1;
                       else begin
                           low = 99;
                           for (int b = 31; b >= 0; b--) if (bus_wdata[b]) low = b;
                           if (low < NC) m_core[ix] = low; else e = 1;
                       end
                    6: begin
                           src = int'(bus_wdata[30:0]);
                           if (ix == 0 && src < NS) m_pend[src] = bus_wdata[31]; else e = 1;
                       end
                    7: if (ix < NC && int'(bus_wdata[5:0]) < NP) begin
                           m_loc_en[ix] = bus_wdata[31]; m_loc_pin[ix] = int'(bus_wdata[5:0]);
                       end else e = 1;
                    default: e = 1;
                endcase
            end
            exp_err = e; exp_rdata = rv;
        end
    end

    // per-cycle comparison against the model
    always @(posedge clk) begin
        #(CLK_P/4);
        if (mon_on && !done) begin
            checks++;
            if (cpu_irq !== model_irq()) begin
                fails++;
                $display("FAIL %s cpu_irq got %h expected %h", cur_req, cpu_irq, model_irq());
            end
            checks++;
            if (bus_err !== exp_err || bus_rdata !== exp_rdata) begin
                fails++;
                $display("FAIL %s err/rdata got %b/%h expected %b/%h",
                         cur_req, bus_err, bus_rdata, exp_err, exp_rdata);
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input bit xerr, input string req);
        @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #(CLK_P/4);
        checks++;
        if (bus_err !== xerr) begin
            fails++;
            $display("FAIL %s write %h err got %b expected %b", req, a, bus_err, xerr);
        end
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] x, input bit xerr, input string req);
        @(negedge clk); bus_rd = 1; bus_addr = a;
        @(posedge clk); #(CLK_P/4);
        checks++;
        if (bus_rdata !== x || bus_err !== xerr) begin
            fails++;
            $display("FAIL %s read %h got %h/%b expected %h/%b", req, a, bus_rdata, bus_err, x, xerr);
        end
        @(negedge clk); bus_rd = 0;
    endtask

    task automatic chk_irq(input logic [NC*NP-1:0] x, input string req);
        #1;
        checks++;
        if (cpu_irq !== x) begin
            fails++;
            $display("FAIL %s cpu_irq got %h expected %h", req, cpu_irq, x);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        mon_on = 1;
        // R1 reset state
        cur_req = "R1";
        chk_irq('0, "R1");
        rd(12'h400, 32'h8000_0000, 0, "R1");
        rd(12'h500, 32'h0, 0, "R1");
        rd(12'h100, 32'h0, 0, "R1");
        rd(12'h702, 32'h8000_0000, 0, "R1");
        // R2 set-mask
        cur_req = "R2";
        wr(12'h200, 32'h5, 0, "R2");
        rd(12'h100, 32'h5, 0, "R2");
        wr(12'h200, 32'h2, 0, "R2");
        rd(12'h100, 32'h7, 0, "R2");
        // R3 clear-mask
        cur_req = "R3";
        wr(12'h300, 32'h1, 0, "R3");
        rd(12'h100, 32'h6, 0, "R3");
        // R4 bitmap word ranges
        cur_req = "R4";
        wr(12'h201, 32'hFFFF_FFFF, 0, "R4");
        rd(12'h101, 32'h0000_00FF, 0, "R4");
        rd(12'h102, 32'h0, 1, "R4");
        // R5 core map
        cur_req = "R5";
        wr(12'h501, 32'h6, 0, "R5");
        rd(12'h501, 32'h2, 0, "R5");
        // R7 core out of range
        cur_req = "R7";
        wr(12'h501, 32'h8, 1, "R7");
        rd(12'h501, 32'h2, 0, "R7");
        // R6 pin map
        cur_req = "R6";
        wr(12'h401, 32'h8000_0003, 0, "R6");
        rd(12'h401, 32'h8000_0003, 0, "R6");
        wr(12'h401, 32'h6, 1, "R6");
        rd(12'h401, 32'h8000_0003, 0, "R6");
        // R8 wedge
        cur_req = "R8";
        wr(12'h600, 32'h8000_0001, 0, "R8");
        chk_irq(18'(1) << 9, "R10");
        rd(12'h000, 32'h2, 0, "R8");
        wr(12'h600, 32'h8000_0028, 1, "R8");
        rd(12'h001, 32'h0, 0, "R8");
        // R10 disabled source records but stays silent
        cur_req = "R10";
        wr(12'h300, 32'h2, 0, "R10");
        chk_irq('0, "R10");
        rd(12'h000, 32'h2, 0, "R10");
        wr(12'h200, 32'h2, 0, "R10");
        chk_irq(18'(1) << 9, "R10");
        // R9 line edges and same-cycle wedge
        cur_req = "R9";
        @(negedge clk); src_irq[2] = 1;
        rd(12'h000, 32'h6, 0, "R9");
        @(negedge clk); src_irq[4] = 1; bus_wr = 1; bus_addr = 12'h600; bus_wdata = 32'h0000_0004;
        @(negedge clk); bus_wr = 0;
        rd(12'h000, 32'h6, 0, "R9");
        @(negedge clk); src_irq[4] = 0;
        @(negedge clk); src_irq[2] = 0;
        rd(12'h000, 32'h2, 0, "R9");
        // R11 local compare route
        cur_req = "R11";
        @(negedge clk); loc_irq[2] = 1;
        chk_irq((18'(1) << 9) | (18'(1) << 12), "R11");
        wr(12'h702, 32'h0000_0004, 0, "R11");
        chk_irq(18'(1) << 9, "R11");
        wr(12'h702, 32'h8000_0004, 0, "R11");
        chk_irq((18'(1) << 9) | (18'(1) << 16), "R11");
        rd(12'h702, 32'h8000_0004, 0, "R11");
        wr(12'h703, 32'h8000_0001, 1, "R11");
        wr(12'h700, 32'h8000_0007, 1, "R11");
        // R12 unsupported accesses
        cur_req = "R12";
        rd(12'hF00, 32'h0, 1, "R12");
        wr(12'h000, 32'h1, 1, "R12");
        rd(12'h000, 32'h2, 0, "R12");
        rd(12'h200, 32'h0, 1, "R12");
        repeat (3) @(negedge clk);
        done = 1;
        summary();
        $finish;
    end

endmodule